// File: doc/BRIEF.md
# Programmable External Memory Access Controller

This block sits beside a small signal processor and turns five of its registers into windows onto external memory. Software first programs a shared control register with two 16-bit transfers, an address and then a mode word. It then touches one of the access registers with a dummy ("blind") read or write. That touch copies the programmed setting into the register's read channel or write channel. After that, every real read of the register fetches a word from external memory, and every real write stores one. Each access advances the channel's stored address by a step that the mode word selects.

The mode word selects the target (program ROM or data DRAM), the step size and its direction. A cell-arrange step alternates between +1 and +31. An overwrite option keeps the old value of every nibble for which the new data nibble is zero. The highest-numbered access register always works through its channels. The others use their channels only while either bank-enable input is high, and otherwise behave as plain storage registers. The external memory answers reads combinationally and takes writes at the clock edge, so one access completes in a single cycle, including the read-modify-write of an overwrite.

Top module: `xmem_port_ctrl`

## Requirements
- R1: The control register (index 5) alternates between an address phase and a mode phase. Any read or write of it moves to the other phase. A write in the address phase stores the address, and a write in the mode phase stores the mode. Leaving the mode phase, by read or by write, arms a pending capture.
- R2: While armed, a blind access to an access register (index 0 to 4) copies the control address and mode into that register's read channel on a read, or into its write channel on a write. It makes no memory access and clears the armed state. A non-blind access while armed clears the armed state and proceeds as a normal access.
- R3: A control read returns the stored control address. After each channel data access, the control register holds that channel's address as updated by the access.
- R4: The step code is mode bits 13:11. Codes 0 to 7 give steps of 0, 1, 2, 4, 8, 16, 32 and 128 words. Mode bit 15 makes the step a decrement. Addresses wrap modulo 2^16.
- R5: A write channel whose mode ANDed with 0x43FF equals 0x0018 writes DRAM (mem_dram=1, mem_addr upper 4 bits zero, lower 16 bits the channel address) and then steps the address per R4.
- R6: A write channel whose mode ANDed with 0xFBFF equals 0x4018 writes DRAM and then adds 31 to an odd address or 1 to an even one.
- R7: With mode bit 10 set on a DRAM or cell write, each 4-bit nibble of the stored word takes the data nibble if that nibble is nonzero, and otherwise keeps the old memory nibble.
- R8: A read channel whose mode ANDed with 0xFFF0 equals 0x0800 reads ROM (mem_dram=0) at mem_addr = {mode[3:0], address}, returns that word and adds 1 to the address.
- R9: A read channel whose mode ANDed with 0x47FF equals 0x0018 reads DRAM at the channel address, returns that word and steps the address per R4.
- R10: Access register 4 always uses its channels. Registers 0 to 3 use their channels only while bank_en is nonzero. Otherwise a write stores the data in the register and a read returns it, with no memory access.
- R11: A data access through a channel whose mode matches none of R5, R6, R8 and R9 makes no memory access, returns 0xFFFF on a read and leaves the channel address unchanged.
- R12: After reset every channel holds address 0 and mode 0. Plain registers read 0, the control register is in its address phase, not armed, and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe (wins over reg_rd) |
| reg_sel | input | 3 | Register index: 0-4 access registers, 5 control |
| reg_blind | input | 1 | Access is a dummy transfer (programming touch) |
| reg_wdata | input | 16 | Register write data |
| bank_en | input | 2 | Channel enable for access registers 0-3 (status bits) |
| reg_rdata | output | 16 | Register read data, valid in the cycle of reg_rd |
| mem_en | output | 1 | External memory access this cycle |
| mem_we | output | 1 | External memory write |
| mem_dram | output | 1 | 1 selects DRAM, 0 selects ROM |
| mem_addr | output | 20 | External word address {page, address} |
| mem_wdata | output | 16 | External write data after nibble merge |
| mem_rdata | input | 16 | External read data, combinational to mem_addr |

## Verification
Two functions meet in the same cycle when an access register is touched while a capture is armed: the capture of a new setting and a memory data transfer through the old channel setting both want that cycle. The bench provokes this with blind and non-blind touches on reset-state and freshly programmed channels. It judges the result by checking that the capture cycle drives no memory strobe, and that a later non-blind read returns either the new setting's ROM word or the old setting's all-ones. The overwrite merge also combines a memory read and a memory write in one cycle. The bench checks the merged data word against nibble values that it computes itself.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

   localparam int MODE_W  = 16;
   localparam int OVW_BIT = 10;
   localparam int DEC_BIT = 15;

   typedef enum logic [2:0] {
      XK_NONE,
      XK_ROM_RD,
      XK_DRAM_RD,
      XK_DRAM_WR,
      XK_CELL_WR
   } xfer_kind_e;

   function automatic xfer_kind_e read_kind(input logic [MODE_W-1:0] m);
      if ((m & 16'hFFF0) == 16'h0800)      return XK_ROM_RD;
      else if ((m & 16'h47FF) == 16'h0018) return XK_DRAM_RD;
      else                                 return XK_NONE;
   endfunction

   function automatic xfer_kind_e write_kind(input logic [MODE_W-1:0] m);
      if ((m & 16'h43FF) == 16'h0018)      return XK_DRAM_WR;
      else if ((m & 16'hFBFF) == 16'h4018) return XK_CELL_WR;
      else                                 return XK_NONE;
   endfunction

   function automatic logic [7:0] step_mag(input logic [2:0] code);
      if (code == 3'd0)      return 8'd0;
      else if (code == 3'd7) return 8'd128;
      else                   return 8'd1 << (code - 3'd1);
   endfunction

endpackage

// File: rtl/xmem_slot_array.sv
module xmem_slot_array #(
   parameter int N     = 5,
   parameter int W     = 32,
   parameter int IDX_W = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [IDX_W-1:0]    idx,
   input  logic [W-1:0]        wd,
   output logic [N-1:0][W-1:0] q
);
   for (genvar i = 0; i < N; i++) begin : g_slot
      logic [W-1:0] r;
      always_ff @(posedge clk) begin
         if (!rst_n)                          r <= '0;
         else if (we && idx == IDX_W'(i))     r <= wd;
      end
      assign q[i] = r;
   end
endmodule

// File: rtl/xmem_ctl_seq.sv
module xmem_ctl_seq #(
   parameter int ADDR_W = 16,
   parameter int MODE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_rd,
   input  logic              ctl_wr,
   input  logic [ADDR_W-1:0] wd_addr,
   input  logic [MODE_W-1:0] wd_mode,
   input  logic              consume,
   input  logic              reload,
   input  logic [ADDR_W-1:0] reload_addr,
   input  logic [MODE_W-1:0] reload_mode,
   output logic              have_addr,
   output logic              armed,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [MODE_W-1:0] cur_mode
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have_addr <= 1'b0;
         armed     <= 1'b0;
         cur_addr  <= '0;
         cur_mode  <= '0;
      end else begin
         if (ctl_wr) begin
            if (have_addr) begin
               cur_mode  <= wd_mode;
               armed     <= 1'b1;
               have_addr <= 1'b0;
            end else begin
               cur_addr  <= wd_addr;
               have_addr <= 1'b1;
            end
         end else if (ctl_rd) begin
            if (have_addr) begin
               armed     <= 1'b1;
               have_addr <= 1'b0;
            end else begin
               have_addr <= 1'b1;
            end
         end
         if (consume) armed <= 1'b0;
         if (reload) begin
            cur_addr <= reload_addr;
            cur_mode <= reload_mode;
         end
      end
   end
endmodule

// File: rtl/xmem_addr_step.sv
module xmem_addr_step
   import xmem_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  xfer_kind_e        kind,
   input  logic [ADDR_W-1:0] addr,
   input  logic [MODE_W-1:0] mode,
   output logic [ADDR_W-1:0] next_addr
);
   logic [ADDR_W-1:0] mag;
   assign mag = ADDR_W'(step_mag(mode[13:11]));

   always_comb begin
      unique case (kind)
         XK_ROM_RD:              next_addr = addr + ADDR_W'(1);
         XK_DRAM_RD, XK_DRAM_WR: next_addr = mode[DEC_BIT] ? addr - mag : addr + mag;
         XK_CELL_WR:             next_addr = addr[0] ? addr + ADDR_W'(31) : addr + ADDR_W'(1);
         default:                next_addr = addr;
      endcase
   end
endmodule

// File: rtl/xmem_nib_merge.sv
module xmem_nib_merge #(
   parameter int DATA_W = 16
) (
   input  logic              en,
   input  logic [DATA_W-1:0] new_d,
   input  logic [DATA_W-1:0] old_d,
   output logic [DATA_W-1:0] out_d
);
   localparam int NIBS = DATA_W / 4;
   for (genvar i = 0; i < NIBS; i++) begin : g_nib
      assign out_d[4*i +: 4] = (!en || new_d[4*i +: 4] != 4'h0) ? new_d[4*i +: 4]
                                                                : old_d[4*i +: 4];
   end
endmodule

// File: rtl/xmem_port_ctrl.sv
module xmem_port_ctrl
   import xmem_pkg::*;
#(
   parameter int NUM_REGS = 5,
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 16,
   parameter int PAGE_W   = 4,
   parameter int BANK_W   = 2,
   parameter int SEL_W    = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_rd,
   input  logic                     reg_wr,
   input  logic [SEL_W-1:0]         reg_sel,
   input  logic                     reg_blind,
   input  logic [DATA_W-1:0]        reg_wdata,
   input  logic [BANK_W-1:0]        bank_en,
   output logic [DATA_W-1:0]        reg_rdata,
   output logic                     mem_en,
   output logic                     mem_we,
   output logic                     mem_dram,
   output logic [PAGE_W+ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0]        mem_wdata,
   input  logic [DATA_W-1:0]        mem_rdata
);
   localparam int CH_W      = ADDR_W + MODE_W;
   localparam int CTL_IDX   = NUM_REGS;
   localparam int FIXED_IDX = NUM_REGS - 1;

   if (DATA_W < MODE_W || DATA_W % 4 != 0) begin : g_bad_data_w
      $error("DATA_W must be a multiple of 4 and at least the mode width");
   end
   if (ADDR_W < 8 || ADDR_W > DATA_W) begin : g_bad_addr_w
      $error("ADDR_W must lie between 8 and DATA_W");
   end
   if (PAGE_W < 1 || PAGE_W > 4) begin : g_bad_page_w
      $error("PAGE_W must lie between 1 and 4");
   end
   if (NUM_REGS < 1 || (1 << SEL_W) <= NUM_REGS) begin : g_bad_sel_w
      $error("SEL_W too narrow to reach the control register");
   end

   logic              have_addr, armed;
   logic [ADDR_W-1:0] cur_addr;
   logic [MODE_W-1:0] cur_mode;

   logic rd_go, wr_go, is_acc, is_ctl, acc_any, chan_path;
   logic capture, consume, data_rd, data_wr, plain_rd, plain_wr;

   assign wr_go     = reg_wr;
   assign rd_go     = reg_rd & ~reg_wr;
   assign is_acc    = reg_sel < SEL_W'(NUM_REGS);
   assign is_ctl    = reg_sel == SEL_W'(CTL_IDX);
   assign acc_any   = (rd_go | wr_go) & is_acc;
   assign chan_path = (reg_sel == SEL_W'(FIXED_IDX)) | (|bank_en);
   assign consume   = acc_any & armed;
   assign capture   = consume & reg_blind;
   assign data_rd   = rd_go & is_acc & ~capture & chan_path;
   assign data_wr   = wr_go & is_acc & ~capture & chan_path;
   assign plain_rd  = rd_go & is_acc & ~capture & ~chan_path;
   assign plain_wr  = wr_go & is_acc & ~capture & ~chan_path;

   // channel storage
   logic [NUM_REGS-1:0][CH_W-1:0]   rd_q, wr_q;
   logic [NUM_REGS-1:0][DATA_W-1:0] plain_q;
   logic [CH_W-1:0]   rd_ch, wr_ch, ch_sel, ch_upd;
   logic [ADDR_W-1:0] ch_addr, next_addr;
   logic [MODE_W-1:0] ch_mode;
   xfer_kind_e        kind;

   assign rd_ch   = is_acc ? rd_q[reg_sel] : '0;
   assign wr_ch   = is_acc ? wr_q[reg_sel] : '0;
   assign ch_sel  = wr_go ? wr_ch : rd_ch;
   assign ch_addr = ch_sel[CH_W-1 -: ADDR_W];
   assign ch_mode = ch_sel[MODE_W-1:0];

   always_comb begin
      if (data_wr)      kind = write_kind(ch_mode);
      else if (data_rd) kind = read_kind(ch_mode);
      else              kind = XK_NONE;
   end

   xmem_addr_step #(.ADDR_W(ADDR_W)) u_step (
      .kind(kind), .addr(ch_addr), .mode(ch_mode), .next_addr(next_addr)
   );

   assign ch_upd = capture ? {cur_addr, cur_mode} : {next_addr, ch_mode};

   xmem_slot_array #(.N(NUM_REGS), .W(CH_W), .IDX_W(SEL_W)) u_rd_slots (
      .clk(clk), .rst_n(rst_n), .we((capture & rd_go) | data_rd),
      .idx(reg_sel), .wd(ch_upd), .q(rd_q)
   );

   xmem_slot_array #(.N(NUM_REGS), .W(CH_W), .IDX_W(SEL_W)) u_wr_slots (
      .clk(clk), .rst_n(rst_n), .we((capture & wr_go) | data_wr),
      .idx(reg_sel), .wd(ch_upd), .q(wr_q)
   );

   xmem_slot_array #(.N(NUM_REGS), .W(DATA_W), .IDX_W(SEL_W)) u_plain (
      .clk(clk), .rst_n(rst_n), .we(plain_wr),
      .idx(reg_sel), .wd(reg_wdata), .q(plain_q)
   );

   xmem_ctl_seq #(.ADDR_W(ADDR_W), .MODE_W(MODE_W)) u_ctl (
      .clk(clk), .rst_n(rst_n),
      .ctl_rd(rd_go & is_ctl), .ctl_wr(wr_go & is_ctl),
      .wd_addr(reg_wdata[ADDR_W-1:0]), .wd_mode(reg_wdata[MODE_W-1:0]),
      .consume(consume), .reload(data_rd | data_wr),
      .reload_addr(next_addr), .reload_mode(ch_mode),
      .have_addr(have_addr), .armed(armed),
      .cur_addr(cur_addr), .cur_mode(cur_mode)
   );

   // external memory side
   assign mem_en   = kind != XK_NONE;
   assign mem_we   = data_wr & (kind != XK_NONE);
   assign mem_dram = kind != XK_ROM_RD;
   assign mem_addr = (kind == XK_ROM_RD) ? {ch_mode[PAGE_W-1:0], ch_addr}
                                         : {{PAGE_W{1'b0}}, ch_addr};

   xmem_nib_merge #(.DATA_W(DATA_W)) u_merge (
      .en(ch_mode[OVW_BIT]), .new_d(reg_wdata), .old_d(mem_rdata), .out_d(mem_wdata)
   );

   // register read data
   always_comb begin
      reg_rdata = '0;
      if (rd_go) begin
         if (is_ctl)        reg_rdata = DATA_W'(cur_addr);
         else if (data_rd)  reg_rdata = (kind != XK_NONE) ? mem_rdata : '1;
         else if (plain_rd) reg_rdata = plain_q[reg_sel];
         else               reg_rdata = '1;
      end
   end
endmodule

// File: rtl/xmem_port_ctrl_chk.sv
module xmem_port_ctrl_chk #(
   parameter int NUM_REGS = 5,
   parameter int ADDR_W   = 16,
   parameter int PAGE_W   = 4,
   parameter int BANK_W   = 2,
   parameter int SEL_W    = 3
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     reg_rd,
   input logic                     reg_wr,
   input logic [SEL_W-1:0]         reg_sel,
   input logic                     reg_blind,
   input logic [BANK_W-1:0]        bank_en,
   input logic                     mem_en,
   input logic                     mem_we,
   input logic                     mem_dram,
   input logic [PAGE_W+ADDR_W-1:0] mem_addr,
   input logic                     have_addr,
   input logic                     armed,
   input logic [ADDR_W-1:0]        cur_addr
);
   logic ctl_hit, acc_hit;
   assign ctl_hit = (reg_rd || reg_wr) && reg_sel == SEL_W'(NUM_REGS);
   assign acc_hit = (reg_rd || reg_wr) && reg_sel < SEL_W'(NUM_REGS);

   // R1
   ctl_addr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == SEL_W'(NUM_REGS) && !have_addr) |=> have_addr);

   // R1
   ctl_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_hit && have_addr) |=> (armed && !have_addr));

   // R2
   arm_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_hit && armed) |=> !armed);

   // R2
   capture_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_hit && armed && reg_blind) |-> !mem_en);

   // R5
   we_dram_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_en && mem_dram));

   // R8
   rom_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && !mem_dram) |=> cur_addr == ADDR_W'($past(mem_addr[ADDR_W-1:0]) + ADDR_W'(1)));

   // R10
   plain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_hit && reg_sel != SEL_W'(NUM_REGS - 1) && bank_en == '0) |-> !mem_en);
endmodule

bind xmem_port_ctrl xmem_port_ctrl_chk #(
   .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BANK_W(BANK_W), .SEL_W(SEL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_sel(reg_sel),
   .reg_blind(reg_blind), .bank_en(bank_en), .mem_en(mem_en), .mem_we(mem_we),
   .mem_dram(mem_dram), .mem_addr(mem_addr), .have_addr(have_addr), .armed(armed),
   .cur_addr(cur_addr)
);

// File: tb/sim_xmem_port_ctrl.sv
module sim_xmem_port_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_rd = 1'b0, reg_wr = 1'b0, reg_blind = 1'b0;
   logic [2:0]  reg_sel = '0;
   logic [15:0] reg_wdata = '0;
   logic [1:0]  bank_en = '0;
   logic [15:0] reg_rdata, mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic        mem_en, mem_we, mem_dram;
   logic [19:0] mem_addr;

   int n_chk = 0, n_bad = 0, mem_gen = 0;
   bit done = 0;
   logic [15:0] dram [int];

   logic [15:0] o_rd, o_wd;
   logic        o_en, o_we, o_dram;
   logic [19:0] o_addr;

   localparam logic [2:0] CTL = 3'd5;

   always #5 clk = ~clk;

   xmem_port_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_blind(reg_blind), .reg_wdata(reg_wdata), .bank_en(bank_en),
      .reg_rdata(reg_rdata), .mem_en(mem_en), .mem_we(mem_we), .mem_dram(mem_dram),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   function automatic logic [15:0] rom_word(input logic [19:0] a);
      int v;
      v = int'(a) * 40503 + 4951;
      return v[15:0] ^ {a[19:16], 12'h000};
   endfunction

   always @(mem_addr or mem_dram or mem_gen) begin
      if (mem_dram) mem_rdata = dram.exists(int'(mem_addr)) ? dram[int'(mem_addr)] : 16'h0000;
      else          mem_rdata = rom_word(mem_addr);
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic op(input logic rd, input logic wr, input logic [2:0] sel,
                     input logic bl, input logic [15:0] d);
      reg_rd = rd; reg_wr = wr; reg_sel = sel; reg_blind = bl; reg_wdata = d;
      #2;
      o_rd = reg_rdata; o_en = mem_en; o_we = mem_we; o_dram = mem_dram;
      o_addr = mem_addr; o_wd = mem_wdata;
      @(posedge clk);
      if (o_en && o_we) begin
         dram[int'(o_addr)] = o_wd;
         mem_gen++;
      end
      @(negedge clk);
      reg_rd = 1'b0; reg_wr = 1'b0; reg_blind = 1'b0;
   endtask

   task automatic prog(input logic [15:0] a, input logic [15:0] m);
      op(0, 1, CTL, 0, a);
      op(0, 1, CTL, 0, m);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      bank_en = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      @(negedge clk);
      // reset state (R12)
      do_reset();
      op(1, 0, 3'd4, 0, 0);
      chk("R12 chan mode0 read", o_rd, 16'hFFFF);
      chk("R12 no mem access", o_en, 1'b0);
      op(1, 0, 3'd0, 0, 0);
      chk("R12 plain reg zero", o_rd, 16'h0000);
      op(1, 0, CTL, 0, 0);
      chk("R12 control readback zero", o_rd, 16'h0000);

      // ROM read channel, page bits, +1 step (R8, R3, R1)
      do_reset();
      prog(16'h0100, 16'h0803);
      op(1, 0, 3'd4, 1, 0);
      chk("R2 capture makes no access", o_en, 1'b0);
      for (int i = 0; i < 3; i++) begin
         op(1, 0, 3'd4, 0, 0);
         chk("R8 rom data", o_rd, rom_word(20'h30100 + 20'(i)));
         chk("R8 rom addr", o_addr, 20'h30100 + 20'(i));
         chk("R8 rom select", o_dram, 1'b0);
      end
      op(1, 0, CTL, 0, 0);
      chk("R3 readback after steps", o_rd, 16'h0103);
      op(1, 0, CTL, 0, 0);                      // R1: read completes mode phase and arms
      bank_en = 2'b01;
      op(1, 0, 3'd1, 1, 0);
      op(1, 0, 3'd1, 0, 0);
      chk("R1 arm by control reads", o_rd, rom_word(20'h30103));
      chk("R10 bank enabled reg1", o_en, 1'b1);
      bank_en = 2'b00;

      // DRAM write and read sweep over all step codes and both directions (R4, R5, R9)
      do_reset();
      for (int dir = 0; dir < 2; dir++) begin
         for (int code = 0; code < 8; code++) begin
            int mag;
            logic [15:0] base, a1, a2, mode, v0, v1;
            mag  = (code == 0) ? 0 : (code == 7) ? 128 : (1 << (code - 1));
            base = 16'h4000 + 16'(code * 512) + 16'(dir * 4096);
            a1   = dir ? base - 16'(mag) : base + 16'(mag);
            a2   = dir ? a1 - 16'(mag) : a1 + 16'(mag);
            mode = 16'h0018 | 16'(code << 11) | 16'(dir << 15);
            v0   = 16'h1000 + 16'(code * 16 + dir);
            v1   = v0 ^ 16'hF0F0;
            prog(base, mode);
            op(0, 1, 3'd4, 1, 0);
            op(0, 1, 3'd4, 0, v0);
            chk("R5 dram write strobe", {o_en, o_we, o_dram}, 3'b111);
            chk("R5 dram write addr", o_addr, {4'h0, base});
            op(0, 1, 3'd4, 0, v1);
            chk("R4 stepped write addr", o_addr, {4'h0, a1});
            op(1, 0, CTL, 0, 0);
            chk("R3 R4 readback", o_rd, a2);
            op(1, 0, CTL, 0, 0);
            prog(base, mode);
            op(1, 0, 3'd4, 1, 0);
            op(1, 0, 3'd4, 0, 0);
            chk("R9 dram read first", o_rd, (code == 0) ? v1 : v0);
            chk("R9 dram read addr", o_addr, {4'h0, base});
            op(1, 0, 3'd4, 0, 0);
            chk("R9 dram read second", o_rd, v1);
            chk("R9 R4 stepped read addr", o_addr, {4'h0, a1});
         end
      end

      // cell-arrange step (R6)
      do_reset();
      prog(16'h2005, 16'h4018);
      op(0, 1, 3'd4, 1, 0);
      op(0, 1, 3'd4, 0, 16'h0001);
      chk("R6 cell addr 0", o_addr, 20'h02005);
      op(0, 1, 3'd4, 0, 16'h0002);
      chk("R6 cell odd +31", o_addr, 20'h02024);
      op(0, 1, 3'd4, 0, 16'h0003);
      chk("R6 cell even +1", o_addr, 20'h02025);
      op(0, 1, 3'd4, 0, 16'h0004);
      chk("R6 cell odd +31 again", o_addr, 20'h02044);

      // nibble overwrite (R7)
      do_reset();
      prog(16'h3000, 16'h0018);
      op(0, 1, 3'd4, 1, 0);
      op(0, 1, 3'd4, 0, 16'h1234);
      chk("R7 plain write data", o_wd, 16'h1234);
      prog(16'h3000, 16'h0418);
      op(0, 1, 3'd4, 1, 0);
      op(0, 1, 3'd4, 0, 16'hA0B0);
      chk("R7 overwrite merge", o_wd, 16'hA2B4);
      prog(16'h3000, 16'h4418);
      op(0, 1, 3'd4, 1, 0);
      op(0, 1, 3'd4, 0, 16'h000F);
      chk("R7 cell overwrite merge", o_wd, 16'hA2BF);
      chk("R7 cell overwrite addr", o_addr, 20'h03000);

      // plain registers versus channels (R10)
      do_reset();
      op(0, 1, 3'd2, 0, 16'h5A5A);
      chk("R10 plain write quiet", o_en, 1'b0);
      op(1, 0, 3'd2, 0, 0);
      chk("R10 plain read back", o_rd, 16'h5A5A);
      prog(16'h0700, 16'h0018);
      op(0, 1, 3'd2, 1, 0);
      op(0, 1, 3'd2, 0, 16'h1111);
      chk("R10 disabled channel quiet", o_en, 1'b0);
      bank_en = 2'b10;
      op(0, 1, 3'd2, 0, 16'h2222);
      chk("R10 enabled channel write", {o_we, o_addr}, {1'b1, 20'h00700});
      bank_en = 2'b00;
      op(1, 0, 3'd2, 0, 0);
      chk("R10 plain value kept", o_rd, 16'h1111);

      // unsupported mode (R11)
      do_reset();
      prog(16'h0200, 16'h1234);
      op(1, 0, 3'd4, 1, 0);
      op(1, 0, 3'd4, 0, 0);
      chk("R11 unsupported read data", o_rd, 16'hFFFF);
      chk("R11 unsupported read quiet", o_en, 1'b0);
      op(1, 0, CTL, 0, 0);
      chk("R11 address unchanged rd", o_rd, 16'h0200);
      op(1, 0, CTL, 0, 0);
      op(0, 1, 3'd4, 1, 0);
      op(0, 1, 3'd4, 0, 16'h9999);
      chk("R11 unsupported write quiet", o_en, 1'b0);
      op(1, 0, CTL, 0, 0);
      chk("R11 address unchanged wr", o_rd, 16'h0200);

      // armed but non-blind, and capture direction (R2)
      do_reset();
      prog(16'h0300, 16'h0800);
      op(1, 0, 3'd4, 0, 0);
      chk("R2 nonblind uses old channel", o_rd, 16'hFFFF);
      op(1, 0, 3'd4, 1, 0);
      op(1, 0, 3'd4, 0, 0);
      chk("R2 arm cleared by nonblind", o_rd, 16'hFFFF);
      do_reset();
      prog(16'h0300, 16'h0800);
      op(1, 0, 3'd4, 1, 0);
      op(0, 1, 3'd4, 0, 16'h7777);
      chk("R2 read capture leaves write chan", o_en, 1'b0);
      op(1, 0, 3'd4, 0, 0);
      chk("R2 read capture loaded", o_rd, rom_word(20'h00300));

      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule